// File: doc/BRIEF.md
# Display-Data I2C Target

This block is an I2C target that serves a banked display-identification memory on one host-facing port. Three target addresses are decoded. The memory pair is 0xA0 for writes and 0xA1 for reads. A write-only segment register sits at 0x60. A configuration register is written at 0x62 and read at 0x63. The memory is an internal synchronous RAM that holds 2^BANK_W banks of 2^SEG_W segments, each segment 256 bytes. The host sees exactly one bank at a time.

The host reaches a byte in three steps. It writes the segment register, issues a repeated START, and then does a normal memory access. The segment register is volatile: it only affects accesses until the next STOP.

The configuration register stands in for non-volatile storage, and reset loads it with 0xFF. It chooses the visible bank and gates memory writes. An external select input also takes part in choosing the bank. A second bus master elsewhere can hold the port off through a blocking input.

Top module: `ddc_i2c_target`

## Requirements
- R1: After reset the target releases SDA, the segment register is 0 and the configuration register reads back 0xFF.
- R2: A write to 0xA0 takes one word-address byte and then data bytes. Each data byte is stored at the word address, and the word address then increments in its low PAGE_W (4) bits only: it wraps inside a 16-byte page and its upper bits stay fixed.
- R3: The random read sequence is START, 0xA0, word address, repeated START, 0xA1. It returns the byte at that word address. Further bytes that the host ACKs come from the following addresses, and the full 8-bit word address wraps from 0xFF to 0x00 inside the same segment. SDA is released while the host drives its ACK/NACK bit.
- R4: A data byte written to 0x60 loads the segment register. The memory address is {bank, segment register low SEG_W bits, word address}, so higher segment bits are ignored. Every STOP clears the segment register to 0, which makes segment 0 the default.
- R5: Address 0x61, a read of the segment register, is NACKed.
- R6: A write to 0x62 loads the configuration register from its first data byte. Later data bytes in the same write are ACKed and discarded. A read from 0x63 returns the configuration register on every byte.
- R7: Configuration bit 2 is the write enable. While it is 0, memory data bytes are still ACKed but the memory is left unchanged.
- R8: The visible bank index is configuration bits [1:0], with bit 0 inverted while bank_sel_i is 1.
- R9: While port_blocked_i is 1, every address byte is NACKed.
- R10: Any other target address is NACKed, and the target then ignores the bus until the next START.
- R11: The target changes SDA only while synchronized SCL is low. It pulls SDA low for the ninth-clock ACK and releases it afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| bank_sel_i | input | 1 | External bank select, inverts bank bit 0 |
| port_blocked_i | input | 1 | High while the other port owns the memory |
| sda_drive_o | output | 1 | 1 pulls SDA low (open-drain enable) |

## Verification
The bench sweeps all eight combinations of the two bank bits and the select input. Each combination writes a segment of its own with a page write that starts eight bytes below a page end. It then reads across the 0xFF to 0x00 boundary. A design that carried the page wrap into the upper address bits would overwrite the low bytes that were written first. A design that wrapped reads within a page, or mapped banks or segments wrongly, would return another combination's pattern.

Further tests check the following:
- A STOP clears the segment register, and its upper bits are ignored. A target that kept the pointer would read the wrong segment.
- The 0x61, blocked and unknown addresses are NACKed. A target that acked them would pull the line low.
- A write with write-enable cleared leaves the memory unchanged.
- A second configuration byte cannot overwrite the first.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK
   } link_st_e;

   typedef enum logic [2:0] {
      PH_DEV,
      PH_WORD,
      PH_DATA,
      PH_SEG,
      PH_CFG,
      PH_SKIP
   } phase_e;

   localparam logic [6:0] MEM_DEV    = 7'h50;
   localparam logic [6:0] CFG_DEV    = 7'h31;
   localparam logic [7:0] SEG_WR     = 8'h60;
   localparam int         CFG_WE_BIT = 2;
   localparam logic [7:0] CFG_RESET  = 8'hFF;

endpackage

// File: rtl/ddc_line_sync.sv
module ddc_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ddc_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic              scl_d, sda_d;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_d    <= scl_pipe[STAGES-1];
         sda_d    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_o      = scl_pipe[STAGES-1];
   assign sda_o      = sda_pipe[STAGES-1];
   assign scl_rise_o = scl_o & ~scl_d;
   assign scl_fall_o = ~scl_o & scl_d;
   assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
   assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;

endmodule

// File: rtl/ddc_byte_ram.sv
module ddc_byte_ram #(
   parameter int AW = 11,
   parameter int DW = 8
) (
   input  logic          clk_i,
   input  logic          we_i,
   input  logic [AW-1:0] wa_i,
   input  logic [DW-1:0] wd_i,
   input  logic [AW-1:0] ra_i,
   output logic [DW-1:0] rd_o
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk_i) begin
      if (we_i) mem[wa_i] <= wd_i;
      rd_o <= mem[ra_i];
   end

endmodule

// File: rtl/ddc_i2c_target.sv
module ddc_i2c_target
   import ddc_pkg::*;
#(
   parameter int BANK_W      = 2,
   parameter int SEG_W       = 1,
   parameter int PAGE_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic scl_i,
   input  logic sda_i,
   input  logic bank_sel_i,
   input  logic port_blocked_i,
   output logic sda_drive_o
);

   localparam int         WORD_W    = 8;
   localparam int         AW        = BANK_W + SEG_W + WORD_W;
   localparam logic [7:0] PAGE_MASK = 8'((1 << PAGE_W) - 1);

   if (BANK_W < 1 || BANK_W > 2) begin : g_bad_bank
      $error("ddc_i2c_target: BANK_W must be 1 or 2");
   end
   if (SEG_W < 1 || SEG_W > 8) begin : g_bad_seg
      $error("ddc_i2c_target: SEG_W must be 1..8");
   end
   if (PAGE_W < 1 || PAGE_W > 8) begin : g_bad_page
      $error("ddc_i2c_target: PAGE_W must be 1..8");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   ddc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .scl_o      (scl_s),
      .sda_o      (sda_s),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_det),
      .stop_o     (stop_det)
   );

   link_st_e         state_q;
   phase_e           phase_q;
   logic [2:0]       cnt_q;
   logic             full_q, drive_q, mack_q, tx_pend_q, rd_cfg_q;
   logic [7:0]       sh_q, tx_q, word_q, cfg_q;
   logic [SEG_W-1:0] seg_q;

   // visible bank: generate picks the form for the bank width
   logic [BANK_W-1:0] bank;
   if (BANK_W == 1) begin : g_bank1
      assign bank = cfg_q[0] ^ bank_sel_i;
   end else begin : g_bankn
      assign bank = {cfg_q[BANK_W-1:1], cfg_q[0] ^ bank_sel_i};
   end

   logic [AW-1:0] ram_addr;
   logic [7:0]    ram_rd, tx_src;
   logic          ram_we, byte_evt, load_evt;

   assign ram_addr = {bank, seg_q, word_q};
   assign byte_evt = (state_q == ST_RX) && scl_fall && full_q;
   assign ram_we   = byte_evt && (phase_q == PH_DATA) && cfg_q[CFG_WE_BIT];
   assign tx_src   = rd_cfg_q ? cfg_q : ram_rd;
   assign load_evt = scl_fall &&
                     (((state_q == ST_RX_ACK) && tx_pend_q) ||
                      ((state_q == ST_TX_ACK) && mack_q));

   ddc_byte_ram #(.AW(AW), .DW(8)) u_ram (
      .clk_i (clk_i),
      .we_i  (ram_we),
      .wa_i  (ram_addr),
      .wd_i  (sh_q),
      .ra_i  (ram_addr),
      .rd_o  (ram_rd)
   );

   // decode of a completed byte
   logic   dec_ack, dec_tx, dec_cfg;
   phase_e dec_phase;

   always_comb begin
      dec_ack   = 1'b1;
      dec_tx    = 1'b0;
      dec_cfg   = 1'b0;
      dec_phase = phase_q;
      unique case (phase_q)
         PH_DEV: begin
            dec_phase = PH_SKIP;
            if (port_blocked_i) begin
               dec_ack = 1'b0;
            end else if (sh_q[7:1] == MEM_DEV) begin
               dec_tx = sh_q[0];
               if (!sh_q[0]) dec_phase = PH_WORD;
            end else if (sh_q[7:1] == CFG_DEV) begin
               dec_tx  = sh_q[0];
               dec_cfg = 1'b1;
               if (!sh_q[0]) dec_phase = PH_CFG;
            end else if (sh_q == SEG_WR) begin
               dec_phase = PH_SEG;
            end else begin
               dec_ack = 1'b0;
            end
         end
         PH_WORD: dec_phase = PH_DATA;
         PH_SEG,
         PH_CFG:  dec_phase = PH_SKIP;
         default: dec_phase = phase_q;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= ST_IDLE;
         phase_q   <= PH_DEV;
         cnt_q     <= '0;
         full_q    <= 1'b0;
         drive_q   <= 1'b0;
         mack_q    <= 1'b0;
         tx_pend_q <= 1'b0;
         rd_cfg_q  <= 1'b0;
         sh_q      <= '0;
         tx_q      <= '0;
         word_q    <= '0;
         cfg_q     <= CFG_RESET;
         seg_q     <= '0;
      end else if (stop_det) begin
         state_q <= ST_IDLE;
         phase_q <= PH_DEV;
         drive_q <= 1'b0;
         seg_q   <= '0;
      end else if (start_det) begin
         state_q <= ST_RX;
         phase_q <= PH_DEV;
         cnt_q   <= '0;
         full_q  <= 1'b0;
         drive_q <= 1'b0;
      end else if (load_evt) begin
         state_q <= ST_TX;
         tx_q    <= {tx_src[6:0], 1'b0};
         drive_q <= ~tx_src[7];
         cnt_q   <= '0;
         if (!rd_cfg_q) word_q <= word_q + 8'd1;
      end else begin
         unique case (state_q)
            ST_RX: begin
               if (scl_rise) begin
                  sh_q  <= {sh_q[6:0], sda_s};
                  cnt_q <= cnt_q + 3'd1;
                  if (cnt_q == 3'd7) full_q <= 1'b1;
               end else if (byte_evt) begin
                  full_q  <= 1'b0;
                  phase_q <= dec_phase;
                  if (dec_ack) begin
                     drive_q <= 1'b1;
                     state_q <= ST_RX_ACK;
                  end else begin
                     state_q <= ST_IDLE;
                  end
                  unique case (phase_q)
                     PH_DEV: begin
                        tx_pend_q <= dec_tx;
                        rd_cfg_q  <= dec_cfg;
                     end
                     PH_WORD: word_q <= sh_q;
                     PH_DATA: word_q <= (word_q & ~PAGE_MASK) |
                                        ((word_q + 8'd1) & PAGE_MASK);
                     PH_SEG:  seg_q  <= sh_q[SEG_W-1:0];
                     PH_CFG:  cfg_q  <= sh_q;
                     default: ;
                  endcase
               end
            end
            ST_RX_ACK: begin
               if (scl_fall) begin
                  drive_q <= 1'b0;
                  state_q <= ST_RX;
                  cnt_q   <= '0;
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (cnt_q == 3'd7) begin
                     drive_q <= 1'b0;
                     state_q <= ST_TX_ACK;
                  end else begin
                     drive_q <= ~tx_q[7];
                     tx_q    <= {tx_q[6:0], 1'b0};
                     cnt_q   <= cnt_q + 3'd1;
                  end
               end
            end
            ST_TX_ACK: begin
               if (scl_rise) mack_q <= ~sda_s;
               else if (scl_fall) state_q <= ST_IDLE;
            end
            default: ;
         endcase
      end
   end

   assign sda_drive_o = drive_q;

endmodule

module ddc_i2c_target_chk
   import ddc_pkg::*;
#(
   parameter int SEG_W  = 1,
   parameter int PAGE_W = 4
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             scl_s,
   input logic             stop_det,
   input logic             port_blocked_i,
   input logic             sda_drive_o,
   input phase_e           phase_q,
   input link_st_e         state_q,
   input logic [SEG_W-1:0] seg_q,
   input logic [7:0]       word_q,
   input logic             ram_we
);

   localparam logic [7:0] PMASK = 8'((1 << PAGE_W) - 1);

   // R9: no address ACK while the port is blocked
   p_blocked_nack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(sda_drive_o) && ($past(phase_q) == PH_DEV)) |-> !$past(port_blocked_i))
      else $error("p_blocked_nack_r9");

   // R4: segment register is zero the cycle after a STOP
   p_seg_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(stop_det) |-> (seg_q == '0))
      else $error("p_seg_clear_r4");

   // R2: write address advances only inside its page
   p_page_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ram_we |=> (((word_q & ~PMASK) == ($past(word_q) & ~PMASK)) &&
                  ((word_q & PMASK) == (($past(word_q) + 8'd1) & PMASK))))
      else $error("p_page_wrap_r2");

   // R11: SDA is pulled low only while SCL is low
   p_drive_scl_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sda_drive_o) |-> !scl_s)
      else $error("p_drive_scl_low_r11");

   // R3: SDA released during the host acknowledge bit
   p_tx_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_TX_ACK) |-> !sda_drive_o)
      else $error("p_tx_release_r3");

endmodule

bind ddc_i2c_target ddc_i2c_target_chk #(.SEG_W(SEG_W), .PAGE_W(PAGE_W)) u_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .scl_s          (scl_s),
   .stop_det       (stop_det),
   .port_blocked_i (port_blocked_i),
   .sda_drive_o    (sda_drive_o),
   .phase_q        (phase_q),
   .state_q        (state_q),
   .seg_q          (seg_q),
   .word_q         (word_q),
   .ram_we         (ram_we)
);

// File: tb/test_ddc_i2c_target.sv
`timescale 1ns/1ps
module test_ddc_i2c_target;

   localparam int Q = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic host_sda = 1'b1;
   logic sel = 1'b0;
   logic blocked = 1'b0;
   logic drive;
   logic sda_line;

   assign sda_line = host_sda & ~drive;

   always #2.5 clk = ~clk;

   ddc_i2c_target i_ddc_i2c_target (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .scl_i          (scl),
      .sda_i          (sda_line),
      .bank_sel_i     (sel),
      .port_blocked_i (blocked),
      .sda_drive_o    (drive)
   );

   int total = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [7:0] model [0:7][0:255];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      host_sda = 1'b1; wq(Q);
      scl = 1'b1;      wq(Q);
      host_sda = 1'b0; wq(Q);
      scl = 1'b0;      wq(Q);
   endtask

   task automatic bus_stop();
      host_sda = 1'b0; wq(Q);
      scl = 1'b1;      wq(Q);
      host_sda = 1'b1; wq(2*Q);
   endtask

   task automatic send(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         host_sda = b[i]; wq(Q);
         scl = 1'b1;      wq(2*Q);
         scl = 1'b0;      wq(Q);
      end
      host_sda = 1'b1; wq(Q);
      scl = 1'b1;      wq(Q);
      acked = (sda_line == 1'b0);
      wq(Q);
      scl = 1'b0;      wq(Q);
   endtask

   task automatic recv(input bit host_ack, output logic [7:0] d);
      host_sda = 1'b1;
      d = '0;
      for (int i = 0; i < 8; i++) begin
         wq(Q);
         scl = 1'b1; wq(Q);
         d = {d[6:0], sda_line};
         wq(Q);
         scl = 1'b0; wq(Q);
      end
      host_sda = ~host_ack; wq(Q);
      scl = 1'b1;           wq(2*Q);
      scl = 1'b0;           wq(Q);
      host_sda = 1'b1;
   endtask

   function automatic logic [7:0] pat(input int c, input int base, input int i);
      return 8'((c * 53 + base + i * 17 + 9) & 255);
   endfunction

   // bank index per R8: cfg[1:0] with bit 0 inverted when select is high
   function automatic int slot_of(input int ab, input int s, input int seg);
      return ((ab ^ s) * 2) + (seg & 1);
   endfunction

   task automatic cfg_write(input logic [7:0] v);
      bit a0, a1;
      bus_start(); send(8'h62, a0); send(v, a1); bus_stop();
      chk(a0 && a1, "R6 cfg write acked", {a0, a1}, 3);
   endtask

   task automatic cfg_read(input int n, output logic [7:0] v);
      bit a;
      logic [7:0] d;
      bus_start(); send(8'h63, a);
      chk(a, "R6 cfg read address acked", a, 1);
      v = '0;
      for (int i = 0; i < n; i++) begin
         recv(i != n - 1, d);
         if (i == 0) v = d;
         chk(d == v, "R6 cfg read repeats", d, v);
      end
      bus_stop();
   endtask

   task automatic write_run(input bit seg_on, input logic [7:0] segv, input logic [7:0] addr,
                            input int n, input int c, input int base, input int slot,
                            input bit upd, input string req);
      bit a, all_ok;
      logic [7:0] wa;
      all_ok = 1'b1;
      bus_start();
      if (seg_on) begin
         send(8'h60, a); all_ok &= a;
         send(segv, a);  all_ok &= a;
         bus_start();
      end
      send(8'hA0, a); all_ok &= a;
      send(addr, a);  all_ok &= a;
      wa = addr;
      for (int i = 0; i < n; i++) begin
         send(pat(c, base, i), a); all_ok &= a;
         if (upd) model[slot][wa] = pat(c, base, i);
         wa = {wa[7:4], 4'(wa[3:0] + 4'd1)};
      end
      bus_stop();
      chk(all_ok, req, all_ok, 1);
   endtask

   task automatic read_run(input bit seg_on, input logic [7:0] segv, input logic [7:0] addr,
                           input int n, input int slot, input string req);
      bit a, all_ok;
      logic [7:0] d, ra;
      all_ok = 1'b1;
      bus_start();
      if (seg_on) begin
         send(8'h60, a); all_ok &= a;
         send(segv, a);  all_ok &= a;
         bus_start();
      end
      send(8'hA0, a); all_ok &= a;
      send(addr, a);  all_ok &= a;
      bus_start();
      send(8'hA1, a); all_ok &= a;
      chk(all_ok, {req, " addressing acked"}, all_ok, 1);
      ra = addr;
      for (int i = 0; i < n; i++) begin
         recv(i != n - 1, d);
         chk(d == model[slot][ra], req, d, model[slot][ra]);
         ra = ra + 8'd1;
      end
      bus_stop();
   endtask

   initial begin : main
      logic [7:0] v;
      bit a;
      rst_n = 1'b0;
      wq(10);
      rst_n = 1'b1;
      wq(10);

      // R1: reset state
      chk(drive == 1'b0, "R1 SDA released after reset", drive, 0);
      cfg_read(1, v);
      chk(v == 8'hFF, "R1 cfg reset value", v, 8'hFF);

      // R11: ACK given then released
      bus_start(); send(8'h63, a);
      chk(a, "R11 ack on ninth clock", a, 1);
      chk(drive == 1'b0, "R11 SDA released after ack", drive, 0);
      recv(1'b0, v);
      bus_stop();

      // R2 R4 R8: sweep bank bits and select input, segment = select
      for (int c = 0; c < 8; c++) begin
         sel = c[2];
         cfg_write(8'hFC | 8'(c & 3));
         write_run(1'b1, 8'(c >> 2), 8'h00, 4, c, 100, slot_of(c & 3, c >> 2, c >> 2), 1'b1,
                   "R2 low page write acked");
         write_run(1'b1, 8'(c >> 2), 8'hF8, 12, c, 0, slot_of(c & 3, c >> 2, c >> 2), 1'b1,
                   "R2 page wrap write acked");
      end
      for (int c = 0; c < 8; c++) begin
         sel = c[2];
         cfg_write(8'hFC | 8'(c & 3));
         read_run(1'b1, 8'(c >> 2), 8'hF8, 12, slot_of(c & 3, c >> 2, c >> 2),
                  "R3 R8 R2 sequential read across 0xFF");
      end

      // R4: segment cleared by STOP, upper segment bits ignored
      sel = 1'b0;
      cfg_write(8'hFD);
      bus_start(); send(8'h60, a); send(8'h01, a); bus_stop();
      read_run(1'b0, 8'h00, 8'hF8, 2, slot_of(1, 0, 0), "R4 segment cleared by STOP");
      read_run(1'b1, 8'h03, 8'hF8, 2, slot_of(1, 0, 1), "R4 upper segment bits ignored");

      // R5 and R10: NACKs, target ignores bus afterwards
      bus_start(); send(8'h61, a); bus_stop();
      chk(!a, "R5 segment read address nacked", a, 0);
      bus_start(); send(8'h44, a);
      chk(!a, "R10 unknown address nacked", a, 0);
      send(8'h00, a);
      chk(!a, "R10 silent until next START", a, 0);
      bus_stop();

      // R6: second configuration byte discarded
      bus_start(); send(8'h62, a); send(8'hFD, a); send(8'h00, a);
      chk(a, "R6 extra cfg byte acked", a, 1);
      bus_stop();
      cfg_read(2, v);
      chk(v == 8'hFD, "R6 first cfg byte kept", v, 8'hFD);

      // R7: write enable cleared (cfg 0xF9: bank 1, bit 2 = 0)
      cfg_write(8'hF9);
      write_run(1'b0, 8'h00, 8'hF8, 2, 7, 55, slot_of(1, 0, 0), 1'b0,
                "R7 data acked with writes disabled");
      read_run(1'b0, 8'h00, 8'hF8, 2, slot_of(1, 0, 0), "R7 memory unchanged");

      // R9: blocked port
      blocked = 1'b1;
      bus_start(); send(8'hA0, a); bus_stop();
      chk(!a, "R9 memory address nacked while blocked", a, 0);
      bus_start(); send(8'h62, a); bus_stop();
      chk(!a, "R9 cfg address nacked while blocked", a, 0);
      blocked = 1'b0;
      cfg_read(1, v);
      chk(v == 8'hF9, "R9 access restored after unblock", v, 8'hF9);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule